// File: doc/BRIEF.md
# Vectored Interrupt Request Controller

This block collects up to thirty-one level-sensitive interrupt lines from peripherals and presents a single interrupt request wire and an 8-bit vector bus to a processor core. Each line is sampled every clock into a raw pending vector. The raw vector is then ANDed with a software-owned enable mask to form the masked pending vector. No priority encoding is done. A lone enabled source gets a vector of its own, 0x31 plus its bit index. Any combination of two or more enabled sources gets the shared vector 0x30. In that case software reads the status and decides the order of service itself.

Software reaches the block through a 32-bit register port with a one-cycle registered response. The enable mask sits at offset 0x0 and is the only writable location. The raw pending vector can be read at 0x4 and the masked pending vector at 0x8. Any access the block does not support raises an error pulse and changes no state. Unsupported accesses are partial-width accesses, writes to offsets other than 0x0, and reads of unknown offsets.

The request and vector outputs are registered. They take the new pending and mask values on the same clock edge that captures those values, so they always agree with the readable status.

Top module: `irq_vec_ctrl`

## Requirements
- R1: The masked pending vector equals the raw pending vector ANDed with the mask, and a full-width read at offset 0x8 returns it.
- R2: When exactly one masked bit i (0 to 30) is set, irq_req is 1 and irq_vec is 0x31 + i.
- R3: When two or more masked bits are set, irq_req is 1 and irq_vec is 0x30.
- R4: When no masked bit is set, irq_req is 0 and irq_vec is 0.
- R5: Line n of src_i (src_i[n-1]) sets or clears raw pending bit n-1 to its level at each rising clock edge, and a full-width read at offset 0x4 returns the raw vector.
- R6: A mask write takes effect on the clock edge that accepts it, and irq_req/irq_vec reflect the new mask from that same edge.
- R7: A write with acc_be = 4'b1111 at offset 0x0 loads the mask, and a read there returns it. A write to any other offset changes nothing and pulses acc_err one cycle later.
- R8: Any access with acc_be other than 4'b1111 is illegal. It pulses acc_err one cycle later, returns read data 0 and does not write.
- R9: Raw and masked pending bit 31 are always 0. Mask bit 31 is writable but never affects irq_req or irq_vec.
- R10: After reset the mask, raw and masked vectors are 0, irq_req is 0, irq_vec is 0 and acc_err is 0.
- R11: A full-width read of an offset other than 0x0, 0x4 or 0x8 returns 0 and pulses acc_err one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 31 | Level-sensitive interrupt lines; bit n-1 is line n |
| acc_valid | input | 1 | Register access strobe, one cycle per access |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_addr | input | 5 | Byte offset of the register |
| acc_be | input | 4 | Byte enables; only 4'b1111 is supported |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid the cycle after a read |
| acc_err | output | 1 | Illegal-access pulse, the cycle after the access |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 8 | Interrupt vector to the core |

## Verification
The bound checker watches several properties on every cycle. It checks that the request agrees with whether any masked bit is pending, and that an idle request drives vector 0. It checks that a shared vector appears exactly when two or more masked bits are set, and that a unique vector matches its single set bit. It also checks that pending bit 31 stays clear, that raw pending follows the lines of the previous cycle, and that illegal writes leave the mask untouched. The bench scenarios show what a property cannot: the readback contents at each offset, the exact vector for each source index, the same-edge effect of a mask write, and error pulses for partial and misaddressed accesses.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned VEC_W = 8;
  localparam logic [VEC_W-1:0] VEC_SHARED = 8'h30;
  localparam logic [VEC_W-1:0] VEC_BASE   = 8'h31;

  localparam logic [4:0] OFF_MASK   = 5'h00;
  localparam logic [4:0] OFF_RAW    = 5'h04;
  localparam logic [4:0] OFF_MASKED = 5'h08;

  typedef enum logic [1:0] {
    SEL_MASK   = 2'd0,
    SEL_RAW    = 2'd1,
    SEL_MASKED = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_vec_regs.sv
module irq_vec_regs
  import irq_vec_pkg::*;
#(
  parameter int unsigned N_SRC  = 31,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [3:0]        acc_be,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              acc_err,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] raw_o,
  output logic [DATA_W-1:0] masked_o,
  output logic [DATA_W-1:0] masked_next_o
);
  localparam int unsigned PAD_W = DATA_W - N_SRC;

  logic [DATA_W-1:0] mask_q, mask_d;
  logic [DATA_W-1:0] raw_q, raw_d;
  logic [DATA_W-1:0] masked_q, masked_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              err_q, err_d;
  logic              full_w, mask_we;
  reg_sel_e          sel;

  // address decode
  always_comb begin
    sel = SEL_NONE;
    if (acc_addr == ADDR_W'(OFF_MASK))        sel = SEL_MASK;
    else if (acc_addr == ADDR_W'(OFF_RAW))    sel = SEL_RAW;
    else if (acc_addr == ADDR_W'(OFF_MASKED)) sel = SEL_MASKED;
  end

  assign full_w  = (acc_be == 4'b1111);
  assign mask_we = acc_valid && acc_write && full_w && (sel == SEL_MASK);

  // next state
  always_comb begin
    raw_d    = {{PAD_W{1'b0}}, src_i};
    mask_d   = mask_we ? acc_wdata : mask_q;
    masked_d = raw_d & mask_d;
    rdata_d  = '0;
    err_d    = 1'b0;
    if (acc_valid) begin
      if (!full_w) begin
        err_d = 1'b1;
      end else if (acc_write) begin
        err_d = (sel != SEL_MASK);
      end else begin
        unique case (sel)
          SEL_MASK:   rdata_d = mask_q;
          SEL_RAW:    rdata_d = raw_q;
          SEL_MASKED: rdata_d = masked_q;
          default:    err_d   = 1'b1;
        endcase
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      raw_q    <= '0;
      masked_q <= '0;
      rdata_q  <= '0;
      err_q    <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_d;
      raw_q    <= raw_d;
      masked_q <= masked_d;
      rdata_q  <= rdata_d;
      err_q    <= err_d;
    end
  end

  assign acc_rdata     = rdata_q;
  assign acc_err       = err_q;
  assign mask_o        = mask_q;
  assign raw_o         = raw_q;
  assign masked_o      = masked_q;
  assign masked_next_o = masked_d;
endmodule

// File: rtl/irq_vec_enc.sv
module irq_vec_enc
  import irq_vec_pkg::*;
#(
  parameter int unsigned N_SRC = 31
) (
  input  logic [N_SRC-1:0] pend_i,
  output logic             req_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [IDX_W-1:0] contrib [N_SRC];
  logic [IDX_W-1:0] idx;
  logic             multi;

  // each set bit contributes its own index; correct only for one-hot input
  for (genvar g = 0; g < N_SRC; g++) begin : g_contrib
    assign contrib[g] = pend_i[g] ? IDX_W'(g) : '0;
  end

  always_comb begin
    idx = '0;
    for (int k = 0; k < N_SRC; k++) idx = idx | contrib[k];
  end

  assign multi = |(pend_i & (pend_i - N_SRC'(1)));
  assign req_o = |pend_i;

  always_comb begin
    if (!req_o)     vec_o = '0;
    else if (multi) vec_o = VEC_SHARED;
    else            vec_o = VEC_BASE + VEC_W'(idx);
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned N_SRC  = 31,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [3:0]        acc_be,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              acc_err,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [DATA_W-1:0] mask_w, raw_w, masked_w, masked_next_w;
  logic              req_d, req_q;
  logic [VEC_W-1:0]  vec_d, vec_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  irq_vec_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .src_i         (src_i),
    .acc_valid     (acc_valid),
    .acc_write     (acc_write),
    .acc_addr      (acc_addr),
    .acc_be        (acc_be),
    .acc_wdata     (acc_wdata),
    .acc_rdata     (acc_rdata),
    .acc_err       (acc_err),
    .mask_o        (mask_w),
    .raw_o         (raw_w),
    .masked_o      (masked_w),
    .masked_next_o (masked_next_w)
  );

  irq_vec_enc #(.N_SRC(N_SRC)) u_enc (
    .pend_i (masked_next_w[N_SRC-1:0]),
    .req_o  (req_d),
    .vec_o  (vec_d)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else begin
      req_q <= req_d;
      vec_q <= vec_d;
    end
  end

  assign irq_req = req_q;
  assign irq_vec = vec_q;
endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk
  import irq_vec_pkg::*;
#(
  parameter int unsigned N_SRC  = 31,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic [N_SRC-1:0]  src_i,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [3:0]        acc_be,
  input logic              acc_err,
  input logic [DATA_W-1:0] mask_w,
  input logic [DATA_W-1:0] raw_w,
  input logic [DATA_W-1:0] masked_w,
  input logic              irq_req,
  input logic [VEC_W-1:0]  irq_vec
);
  logic armed;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) armed <= 1'b0;
    else            armed <= 1'b1;
  end

  AST_REQ_TRACKS_PENDING: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_req == (masked_w != '0));                                          // R4
  AST_IDLE_VECTOR_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    !irq_req |-> irq_vec == '0);                                           // R4
  AST_SHARED_WHEN_MANY: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($countones(masked_w) >= 2) == (irq_vec == VEC_SHARED));               // R3
  AST_UNIQUE_MATCHES_BIT: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($countones(masked_w) == 1) |-> masked_w[irq_vec - VEC_BASE]);         // R2
  AST_MASKED_SUBSET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (masked_w & ~(raw_w & mask_w)) == '0);                                 // R1
  AST_TOP_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_int_n)
    !raw_w[DATA_W-1] && !masked_w[DATA_W-1]);                              // R9
  AST_RAW_FOLLOWS_LINES: assert property (@(posedge clk) disable iff (!rst_int_n || !armed)
    raw_w[N_SRC-1:0] == $past(src_i));                                     // R5
  AST_BAD_WRITE_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_valid && acc_write && (acc_be != 4'b1111 || acc_addr != ADDR_W'(OFF_MASK)))
      |=> $stable(mask_w));                                                // R7
  AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_int_n || !armed)
    acc_err |-> $past(acc_valid));                                         // R8
endmodule

bind irq_vec_ctrl irq_vec_chk #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .src_i     (src_i),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .acc_addr  (acc_addr),
  .acc_be    (acc_be),
  .acc_err   (acc_err),
  .mask_w    (mask_w),
  .raw_w     (raw_w),
  .masked_w  (masked_w),
  .irq_req   (irq_req),
  .irq_vec   (irq_vec)
);

// File: tb/tb_irq_vec_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vec_ctrl;
  localparam int N = 31;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [N-1:0] src_i;
  logic        acc_valid, acc_write;
  logic [4:0]  acc_addr;
  logic [3:0]  acc_be;
  logic [31:0] acc_wdata;
  logic [31:0] acc_rdata;
  logic        acc_err, irq_req;
  logic [7:0]  irq_vec;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // model state
  logic [31:0] m_mask, m_raw;
  logic [31:0] e_rdata;
  logic        e_err;

  always #10 clk = ~clk;  // 50 MHz

  irq_vec_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_be(acc_be), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .acc_err(acc_err), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  function automatic logic [7:0] exp_vec(input logic [31:0] m);
    int cnt = 0;
    int pos = 0;
    for (int i = 0; i < 31; i++) if (m[i]) begin cnt++; pos = i; end
    if (cnt == 0) return 8'h00;
    if (cnt > 1)  return 8'h30;
    return 8'(8'h31 + pos);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, update model, clock, check at next negedge
  task automatic cycle(input logic [N-1:0] lines, input bit v, input bit w,
                       input logic [4:0] a, input logic [3:0] be,
                       input logic [31:0] wd, input string req);
    logic [31:0] masked;
    src_i = lines; acc_valid = v; acc_write = w; acc_addr = a;
    acc_be = be; acc_wdata = wd;
    e_rdata = '0; e_err = 1'b0;
    if (v) begin
      if (be != 4'hF) e_err = 1'b1;
      else if (w) begin
        if (a == 5'h0) m_mask = wd; else e_err = 1'b1;
      end else begin
        case (a)
          5'h0: e_rdata = m_mask;
          5'h4: e_rdata = m_raw;
          5'h8: e_rdata = m_raw & m_mask;
          default: e_err = 1'b1;
        endcase
      end
    end
    m_raw = {1'b0, lines};
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    masked = m_raw & m_mask;
    check(req, "irq_req", 32'(irq_req), 32'(masked != 0));
    check(req, "irq_vec", 32'(irq_vec), 32'(exp_vec(masked)));
    check(req, "acc_err", 32'(acc_err), 32'(e_err));
    check(req, "acc_rdata", acc_rdata, e_rdata);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed1234);
    rst_n = 1'b0; src_i = '0; acc_valid = 0; acc_write = 0;
    acc_addr = '0; acc_be = 4'hF; acc_wdata = '0;
    m_mask = '0; m_raw = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "irq_req", 32'(irq_req), 0);
    check("R10", "irq_vec", 32'(irq_vec), 0);
    check("R10", "acc_err", 32'(acc_err), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cycle('0, 1, 0, 5'h0, 4'hF, 0, "R10");  // mask reads 0
    cycle('0, 1, 0, 5'h8, 4'hF, 0, "R10");
    // R4: lines active, mask zero
    cycle('1, 1, 0, 5'h4, 4'hF, 0, "R4");
    // R6: write mask with lines active; vector appears same edge
    cycle(31'h1, 1, 1, 5'h0, 4'hF, 32'h1, "R6");
    // R2: each single source in turn
    cycle('0, 1, 1, 5'h0, 4'hF, 32'hFFFF_FFFF, "R7");
    for (int i = 0; i < N; i++) cycle(31'(1) << i, 0, 0, 0, 4'hF, 0, "R2");
    // R3: two and many sources
    cycle(31'h3, 0, 0, 0, 4'hF, 0, "R3");
    cycle(31'h4000_0001, 0, 0, 0, 4'hF, 0, "R3");
    cycle('1, 1, 0, 5'h8, 4'hF, 0, "R1");
    // R9: mask only bit 31 -> no request
    cycle('1, 1, 1, 5'h0, 4'hF, 32'h8000_0000, "R9");
    cycle('1, 1, 0, 5'h0, 4'hF, 0, "R9");
    cycle('1, 1, 0, 5'h8, 4'hF, 0, "R9");
    // R7: writes to other offsets ignored
    cycle(31'h10, 1, 1, 5'h4, 4'hF, 32'hFFFF_FFFF, "R7");
    cycle(31'h10, 1, 1, 5'h8, 4'hF, 32'hFFFF_FFFF, "R7");
    cycle(31'h10, 1, 0, 5'h0, 4'hF, 0, "R7");
    // R8: partial accesses
    cycle(31'h10, 1, 1, 5'h0, 4'h1, 32'h10, "R8");
    cycle(31'h10, 1, 0, 5'h4, 4'h3, 0, "R8");
    cycle(31'h10, 1, 0, 5'h0, 4'hF, 0, "R8");
    // R11: unknown read offsets
    cycle(31'h10, 1, 0, 5'hC, 4'hF, 0, "R11");
    cycle(31'h10, 1, 0, 5'h2, 4'hF, 0, "R11");
    // R5: raw readback follows lines
    cycle(31'h5555_5555, 0, 0, 0, 4'hF, 0, "R5");
    cycle(31'h2AAA_AAAA, 1, 0, 5'h4, 4'hF, 0, "R5");
    cycle(31'h0, 1, 0, 5'h4, 4'hF, 0, "R5");
    // random mix
    for (int k = 0; k < 2000; k++) begin
      logic [N-1:0] ln;
      logic [4:0]   a;
      logic [3:0]   be;
      int sel;
      sel = $urandom_range(0, 3);
      case (sel)
        0: ln = '0;
        1: ln = 31'(1) << $urandom_range(0, N-1);
        2: ln = (31'(1) << $urandom_range(0, N-1)) | (31'(1) << $urandom_range(0, N-1));
        default: ln = 31'($urandom) & 31'($urandom);
      endcase
      a  = ($urandom_range(0, 7) == 0) ? 5'($urandom) : 5'(4 * $urandom_range(0, 2));
      be = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'hF;
      cycle(ln, $urandom_range(0, 1), $urandom_range(0, 2) == 0, a, be,
            ($urandom_range(0, 1) == 1) ? $urandom : 32'hFFFF_FFFF, "R1");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule